// File: doc/BRIEF.md
# Interrupt and Reset Entry Sequencer

This block sits beside an 8-bit processor core at the point where one instruction ends and the next begins. When the core raises `boundary`, the sequencer picks what runs next: a reset entry, a non-maskable interrupt entry, a maskable interrupt entry, or, when nothing is pending, a plain opcode fetch. A plain fetch is reported on `fetch_go` and left to the core. An entry sequence takes the bus for seven cycles. For each cycle the sequencer gives the address, the direction, which byte is written and the write data. At the end it returns the new program counter read from the vector.

The core keeps its registers. The sequencer samples the stack pointer at the start of an entry and reports the decremented copy on `sp_out`. It receives the flags byte to push, and it strobes `set_i` when the interrupt-disable flag must be set. It also holds the request state: a sticky power-on request, edge capture of the non-maskable line, a one-cycle sampled maskable request and edge detection on the set-overflow input. While `rdy` is high, read cycles of a sequence stall.

State names: `ST_IDLE`, `ST_DUM1`, `ST_DUM2`, `ST_PUSH_H`, `ST_PUSH_L`, `ST_PUSH_P`, `ST_RSTK1`, `ST_RSTK2`, `ST_RSTK3`, `ST_VEC_L`, `ST_VEC_H`.

Transitions:
- `ST_IDLE` to `ST_DUM1` when `boundary` is high and a request is pending.
- `ST_DUM1` to `ST_DUM2`.
- `ST_DUM2` to `ST_RSTK1` for a reset, or to `ST_PUSH_H` for an interrupt.
- `ST_PUSH_H` to `ST_PUSH_L` to `ST_PUSH_P` to `ST_VEC_L`.
- `ST_RSTK1` to `ST_RSTK2` to `ST_RSTK3` to `ST_VEC_L`.
- `ST_VEC_L` to `ST_VEC_H` to `ST_IDLE`.

Each of these steps happens on a clock edge unless it is stalled by `rdy`.

Top module: `irq_entry_seq`

## Requirements
- R1: At a boundary the choice is made in this order: reset (power-on request or `reset_in`), then a latched NMI, then a maskable request. With none pending, `fetch_go` is high in that same cycle and `busy` stays low.
- R2: After block reset a power-on request is pending. It clears when a reset entry starts. `reset_in` requests a reset entry at every boundary for as long as it is held high.
- R3: An NMI request latches only on a low-to-high change of `nmi_in`, and it clears when an NMI entry starts. A line held high does not request again.
- R4: The maskable request is `irq_in` AND NOT `i_flag`, registered at each clock edge. A line that rises in the boundary cycle is therefore not taken until the next boundary.
- R5: The vectors are 0xFFFA for NMI, 0xFFFC for reset and 0xFFFE for the maskable interrupt. The low byte is read at the vector and the high byte at vector+1. In the cycle after the high read, `pc_valid` is high, `busy` is low and `pc_out` holds {high, low}.
- R6: An interrupt entry runs two reads at `pc_in`, then three writes at 0x0100 | S with S decreasing by one each time, then the two vector reads. The writes are coded on `dsel` as 1 = PC high, 2 = PC low and 3 = flags, and `wdata` carries the matching byte. `dsel` is 0 on every other cycle, and `rw` is 1 for a read.
- R7: `set_i` is high only during the flags push, and only in a maskable-interrupt entry, never in an NMI entry.
- R8: A reset entry runs two reads at `pc_in`, then three reads at 0x0100 | S with S decreasing, and never writes. `sp_out` ends at S-3 for every entry kind.
- R9: If an NMI is latched when the PC-low push of a maskable entry completes, the vector becomes 0xFFFA and the NMI request clears. An NMI that latches later keeps 0xFFFE and stays pending for the next boundary.
- R10: A rising edge on `so_in` gives a one-cycle `set_v` pulse in the following cycle. A held level gives no further pulse.
- R11: While `rdy` is high, a read cycle of a sequence holds its state, address and stack pointer. Write cycles advance regardless of `rdy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low block reset |
| boundary | input | 1 | Core is at an instruction boundary |
| rdy | input | 1 | Stall request for read cycles |
| reset_in | input | 1 | Processor reset request, level |
| nmi_in | input | 1 | Non-maskable interrupt line, edge sensitive |
| irq_in | input | 1 | Maskable interrupt line, level |
| so_in | input | 1 | Set-overflow line |
| i_flag | input | 1 | Interrupt-disable flag from the core |
| sp_in | input | 8 | Stack pointer from the core |
| pc_in | input | 16 | Program counter from the core |
| flags_in | input | 8 | Flags byte to push |
| rdata | input | 8 | Bus read data |
| fetch_go | output | 1 | No entry pending: core fetches an opcode |
| busy | output | 1 | An entry sequence owns the bus |
| seq_kind | output | 2 | 0 none, 1 reset, 2 NMI, 3 maskable |
| addr | output | 16 | Bus address |
| rw | output | 1 | 1 read, 0 write |
| dsel | output | 2 | Write data source (see R6) |
| wdata | output | 8 | Write data |
| set_i | output | 1 | Set interrupt-disable strobe |
| set_v | output | 1 | Set overflow strobe |
| vector | output | 16 | Selected vector address |
| sp_out | output | 8 | Working stack pointer |
| pc_out | output | 16 | Program counter read from the vector |
| pc_valid | output | 1 | `pc_out` is new this cycle |

## Verification
The bench raises an NMI during the PC-high push of a maskable entry and expects 0xFFFE to become 0xFFFA with no later NMI entry. A design that samples the redirect at the wrong step would either keep 0xFFFE or take the NMI twice. It also raises the NMI one cycle later and expects no redirect but a pending NMI. A design that missed the step would lose the interrupt. It raises the maskable line in the boundary cycle itself; a design without the sampling register would start the entry one boundary early. It also holds `rdy` on a stack read and on a push: a design that stalls writes, or lets reads run through, would show a shifted address trace.

// File: rtl/irqs_pkg.sv
package irqs_pkg;
    localparam int AW = 16;
    localparam int DW = 8;
    localparam int NPUSH = 3;
    localparam logic [AW-1:0] VEC_NMI = 16'hFFFA;
    localparam logic [AW-1:0] VEC_RST = 16'hFFFC;
    localparam logic [AW-1:0] VEC_IRQ = 16'hFFFE;
    localparam logic [DW-1:0] STACK_PAGE = 8'h01;

    typedef enum logic [3:0] {
        ST_IDLE, ST_DUM1, ST_DUM2, ST_PUSH_H, ST_PUSH_L, ST_PUSH_P,
        ST_RSTK1, ST_RSTK2, ST_RSTK3, ST_VEC_L, ST_VEC_H
    } seq_state_t;

    typedef enum logic [1:0] {K_NONE, K_RESET, K_NMI, K_IRQ} seq_kind_t;
    typedef enum logic [1:0] {DS_NONE, DS_PCH, DS_PCL, DS_FLAGS} dsel_t;
endpackage

// File: rtl/irqs_req.sv
module irqs_req
    import irqs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic reset_in,
    input  logic nmi_in,
    input  logic irq_in,
    input  logic i_flag,
    input  logic so_in,
    input  logic take_reset,
    input  logic take_nmi,
    output logic rst_req,
    output logic nmi_pend,
    output logic irq_req,
    output logic set_v
);
    logic pwr_on, nmi_prev, so_prev;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwr_on   <= 1'b1;
            nmi_prev <= 1'b0;
            nmi_pend <= 1'b0;
            irq_req  <= 1'b0;
            so_prev  <= 1'b0;
            set_v    <= 1'b0;
        end else begin
            nmi_prev <= nmi_in;
            so_prev  <= so_in;
            set_v    <= so_in & ~so_prev;
            irq_req  <= irq_in & ~i_flag;
            if (take_reset)
                pwr_on <= 1'b0;
            if (nmi_in && !nmi_prev)
                nmi_pend <= 1'b1;
            else if (take_nmi)
                nmi_pend <= 1'b0;
        end
    end

    assign rst_req = reset_in | pwr_on;

    assert_pwr_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        take_reset |=> (rst_req == reset_in));
    assert_nmi_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nmi_pend) |-> $past(nmi_in));
    assert_irq_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> $past(!i_flag));
    assert_setv_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        set_v |=> !set_v);
endmodule

// File: rtl/irqs_fsm.sv
module irqs_fsm
    import irqs_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          boundary,
    input  logic          rdy,
    input  logic          rst_req,
    input  logic          nmi_pend,
    input  logic          irq_req,
    input  logic [DW-1:0] sp_in,
    input  logic [AW-1:0] pc_in,
    input  logic [DW-1:0] flags_in,
    input  logic [DW-1:0] rdata,
    output logic          take_reset,
    output logic          take_nmi,
    output logic          fetch_go,
    output logic          busy,
    output seq_kind_t     kind,
    output logic [AW-1:0] addr,
    output logic          rw,
    output dsel_t         dsel,
    output logic [DW-1:0] wdata,
    output logic          set_i,
    output logic [AW-1:0] vector,
    output logic [DW-1:0] sp_out,
    output logic [AW-1:0] pc_out,
    output logic          pc_valid
);
    seq_state_t state, nxt;
    seq_kind_t  start_kind;
    logic [DW-1:0] sp, pc_lo;
    logic [AW-1:0] vec;
    logic stall, at_gate, hijack;

    // boundary arbitration
    always_comb begin
        start_kind = K_NONE;
        if (rst_req)       start_kind = K_RESET;
        else if (nmi_pend) start_kind = K_NMI;
        else if (irq_req)  start_kind = K_IRQ;
    end

    assign at_gate    = (state == ST_IDLE) && boundary;
    assign fetch_go   = at_gate && (start_kind == K_NONE);
    assign take_reset = at_gate && (start_kind == K_RESET);
    assign hijack     = (state == ST_PUSH_L) && (kind == K_IRQ) && nmi_pend;
    assign take_nmi   = (at_gate && (start_kind == K_NMI)) || hijack;
    assign busy       = (state != ST_IDLE);
    assign stall      = rdy && rw && busy;

    // bus outputs per state
    always_comb begin
        addr  = pc_in;
        rw    = 1'b1;
        dsel  = DS_NONE;
        set_i = 1'b0;
        unique case (state)
            ST_IDLE, ST_DUM1, ST_DUM2: addr = pc_in;
            ST_PUSH_H: begin addr = {STACK_PAGE, sp}; rw = 1'b0; dsel = DS_PCH; end
            ST_PUSH_L: begin addr = {STACK_PAGE, sp}; rw = 1'b0; dsel = DS_PCL; end
            ST_PUSH_P: begin
                addr  = {STACK_PAGE, sp};
                rw    = 1'b0;
                dsel  = DS_FLAGS;
                set_i = (kind == K_IRQ);
            end
            ST_RSTK1, ST_RSTK2, ST_RSTK3: addr = {STACK_PAGE, sp};
            ST_VEC_L: addr = vec;
            ST_VEC_H: addr = vec + 16'd1;
        endcase
    end

    always_comb begin
        unique case (dsel)
            DS_PCH:   wdata = pc_in[AW-1:DW];
            DS_PCL:   wdata = pc_in[DW-1:0];
            DS_FLAGS: wdata = flags_in;
            DS_NONE:  wdata = '0;
        endcase
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (at_gate && start_kind != K_NONE) nxt = ST_DUM1;
            ST_DUM1:   nxt = ST_DUM2;
            ST_DUM2:   nxt = (kind == K_RESET) ? ST_RSTK1 : ST_PUSH_H;
            ST_PUSH_H: nxt = ST_PUSH_L;
            ST_PUSH_L: nxt = ST_PUSH_P;
            ST_PUSH_P: nxt = ST_VEC_L;
            ST_RSTK1:  nxt = ST_RSTK2;
            ST_RSTK2:  nxt = ST_RSTK3;
            ST_RSTK3:  nxt = ST_VEC_L;
            ST_VEC_L:  nxt = ST_VEC_H;
            ST_VEC_H:  nxt = ST_IDLE;
        endcase
    end

    // state register and working copies
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            kind     <= K_NONE;
            sp       <= '0;
            vec      <= VEC_RST;
            pc_lo    <= '0;
            pc_out   <= '0;
            pc_valid <= 1'b0;
        end else begin
            pc_valid <= 1'b0;
            if (!stall) begin
                state <= nxt;
                unique case (state)
                    ST_IDLE: if (at_gate && start_kind != K_NONE) begin
                        kind <= start_kind;
                        sp   <= sp_in;
                        vec  <= (start_kind == K_RESET) ? VEC_RST :
                                (start_kind == K_NMI)   ? VEC_NMI : VEC_IRQ;
                    end
                    ST_PUSH_L: begin
                        sp <= sp - 8'd1;
                        if (kind == K_IRQ)
                            vec <= nmi_pend ? VEC_NMI : VEC_IRQ;
                    end
                    ST_PUSH_H, ST_PUSH_P, ST_RSTK1, ST_RSTK2, ST_RSTK3:
                        sp <= sp - 8'd1;
                    ST_VEC_L: pc_lo <= rdata;
                    ST_VEC_H: begin
                        pc_out   <= {rdata, pc_lo};
                        pc_valid <= 1'b1;
                        kind     <= K_NONE;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign vector = vec;
    assign sp_out = sp;

    assert_fetch_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_go |=> !busy);
    assert_done_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pc_valid |-> (!busy && kind == K_NONE));
    assert_seti_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |-> (kind == K_IRQ && !rw));
    assert_rst_reads_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == K_RESET) |-> rw);
    assert_stall_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rw && rdy) |=> (state == $past(state) && sp == $past(sp)));
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import irqs_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          boundary,
    input  logic          rdy,
    input  logic          reset_in,
    input  logic          nmi_in,
    input  logic          irq_in,
    input  logic          so_in,
    input  logic          i_flag,
    input  logic [7:0]    sp_in,
    input  logic [15:0]   pc_in,
    input  logic [7:0]    flags_in,
    input  logic [7:0]    rdata,
    output logic          fetch_go,
    output logic          busy,
    output logic [1:0]    seq_kind,
    output logic [15:0]   addr,
    output logic          rw,
    output logic [1:0]    dsel,
    output logic [7:0]    wdata,
    output logic          set_i,
    output logic          set_v,
    output logic [15:0]   vector,
    output logic [7:0]    sp_out,
    output logic [15:0]   pc_out,
    output logic          pc_valid
);
    logic rst_req, nmi_pend, irq_req, take_reset, take_nmi;
    seq_kind_t kind;
    dsel_t     ds;

    irqs_req u_req (
        .clk(clk), .rst_n(rst_n), .reset_in(reset_in), .nmi_in(nmi_in),
        .irq_in(irq_in), .i_flag(i_flag), .so_in(so_in),
        .take_reset(take_reset), .take_nmi(take_nmi),
        .rst_req(rst_req), .nmi_pend(nmi_pend), .irq_req(irq_req), .set_v(set_v)
    );

    irqs_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .boundary(boundary), .rdy(rdy),
        .rst_req(rst_req), .nmi_pend(nmi_pend), .irq_req(irq_req),
        .sp_in(sp_in), .pc_in(pc_in), .flags_in(flags_in), .rdata(rdata),
        .take_reset(take_reset), .take_nmi(take_nmi), .fetch_go(fetch_go),
        .busy(busy), .kind(kind), .addr(addr), .rw(rw), .dsel(ds),
        .wdata(wdata), .set_i(set_i), .vector(vector), .sp_out(sp_out),
        .pc_out(pc_out), .pc_valid(pc_valid)
    );

    assign seq_kind = kind;
    assign dsel     = ds;
endmodule

// File: tb/sim_irq_entry_seq.sv
module sim_irq_entry_seq;
    logic clk = 1'b0, rst_n = 1'b0;
    logic boundary = 0, rdy = 0, reset_in = 0, nmi_in = 0, irq_in = 0, so_in = 0, i_flag = 0;
    logic [7:0]  sp_in = 8'hFD, flags_in = 8'hA5, rdata = 8'h00;
    logic [15:0] pc_in = 16'h1234;
    logic fetch_go, busy, rw, set_i, set_v, pc_valid;
    logic [1:0] seq_kind, dsel;
    logic [7:0] wdata, sp_out;
    logic [15:0] addr, vector, pc_out;
    int n_chk = 0, n_fail = 0;

    always #5 clk = ~clk;

    irq_entry_seq u0 (.*);

    task automatic tick; @(negedge clk); #1; endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // kind: 1 reset, 2 NMI, 3 maskable
    task automatic walk(input int kind, input logic [7:0] sp0, input logic [15:0] pc0,
                        input logic [15:0] vec, input int nmi_at, input int stall_at);
        logic [7:0] vl, vh;
        vl = pc0[7:0] + 8'd1;
        vh = pc0[15:8] ^ 8'h80;
        sp_in = sp0; pc_in = pc0;
        boundary = 1; tick; boundary = 0;
        chk("R1 kind", seq_kind, kind);
        for (int i = 0; i < 7; i++) begin
            logic [15:0] ea; logic erw; logic [1:0] eds; logic [7:0] ewd;
            eds = 2'd0; ewd = 8'h00; erw = 1'b1;
            if (i < 2) ea = pc0;
            else if (i < 5) begin
                ea = {8'h01, sp0 - 8'(i - 2)};
                if (kind != 1) begin
                    erw = 1'b0; eds = 2'(i - 1);
                    ewd = (i == 2) ? pc0[15:8] : (i == 3) ? pc0[7:0] : flags_in;
                end
            end else if (i == 5) begin ea = vec; rdata = vl; end
            else begin ea = vec + 16'd1; rdata = vh; end
            #1;
            chk(kind == 1 ? "R8 addr" : (i >= 5 ? "R5 addr" : "R6 addr"), addr, ea);
            chk(kind == 1 ? "R8 rw" : "R6 rw", rw, erw);
            chk("R6 dsel", dsel, eds);
            if (!erw) chk("R6 wdata", wdata, ewd);
            chk("R7 set_i", set_i, (kind == 3 && i == 4));
            chk("R6 busy", busy, 1);
            if (i == nmi_at) nmi_in = 1;
            if (i == stall_at) begin
                rdy = 1;
                if (erw) begin
                    tick;
                    chk("R11 held addr", addr, ea);
                    chk("R11 held busy", busy, 1);
                    rdy = 0;
                end
            end
            tick;
            rdy = 0;
        end
        chk("R5 pc_valid", pc_valid, 1);
        chk("R5 pc_out", pc_out, {vh, vl});
        chk("R5 busy low", busy, 0);
        chk("R8 sp_out", sp_out, sp0 - 8'd3);
        tick;
        chk("R5 pc_valid pulse", pc_valid, 0);
    endtask

    task automatic expect_fetch(input string req);
        boundary = 1; #1;
        chk(req, fetch_go, 1);
        tick; boundary = 0;
        chk(req, busy, 0);
    endtask

    task automatic t_reset_state;
        chk("R2 idle", busy, 0);
        chk("R5 no pc", pc_valid, 0);
        chk("R10 no set_v", set_v, 0);
        chk("R1 no fetch", fetch_go, 0);
    endtask

    task automatic t_power_on;
        walk(1, 8'hFD, 16'h1234, 16'hFFFC, -1, -1);
        expect_fetch("R2 power-on cleared");
    endtask

    task automatic t_reset_level;
        reset_in = 1;
        walk(1, 8'h40, 16'h2000, 16'hFFFC, -1, -1);
        walk(1, 8'h3D, 16'h3000, 16'hFFFC, -1, -1);
        reset_in = 0;
        expect_fetch("R2 reset released");
    endtask

    task automatic t_irq;
        irq_in = 1; tick;
        walk(3, 8'hF0, 16'hABCD, 16'hFFFE, -1, -1);
        irq_in = 0; tick; tick;
    endtask

    task automatic t_irq_mask;
        i_flag = 1; irq_in = 1; tick; tick;
        expect_fetch("R4 masked");
        irq_in = 0; i_flag = 0; tick;
    endtask

    task automatic t_irq_late;
        irq_in = 1; boundary = 1; #1;
        chk("R4 one cycle late", fetch_go, 1);
        tick; boundary = 0;
        walk(3, 8'h80, 16'h0456, 16'hFFFE, -1, -1);
        irq_in = 0; tick; tick;
    endtask

    task automatic t_nmi;
        nmi_in = 1; tick;
        walk(2, 8'hE0, 16'h5678, 16'hFFFA, -1, -1);
        expect_fetch("R3 level no retrigger");
        nmi_in = 0; tick;
    endtask

    task automatic t_priority;
        nmi_in = 1; reset_in = 1; irq_in = 1; tick;
        walk(1, 8'h70, 16'h1111, 16'hFFFC, -1, -1);
        reset_in = 0;
        walk(2, 8'h6D, 16'h2222, 16'hFFFA, -1, -1);
        walk(3, 8'h50, 16'h3333, 16'hFFFE, -1, -1);
        irq_in = 0; nmi_in = 0; tick; tick;
        expect_fetch("R1 nothing left");
    endtask

    task automatic t_hijack;
        irq_in = 1; tick;
        walk(3, 8'hC0, 16'h4444, 16'hFFFA, 2, -1);
        irq_in = 0; tick; tick;
        expect_fetch("R9 nmi consumed by hijack");
        nmi_in = 0; tick;
    endtask

    task automatic t_late_nmi;
        irq_in = 1; tick;
        walk(3, 8'hB0, 16'h5555, 16'hFFFE, 3, -1);
        irq_in = 0; tick; tick;
        walk(2, 8'hAD, 16'h6666, 16'hFFFA, -1, -1);
        nmi_in = 0; tick;
    endtask

    task automatic t_rdy;
        irq_in = 1; tick;
        walk(3, 8'h90, 16'h7777, 16'hFFFE, -1, 2);
        irq_in = 0; tick; tick;
        reset_in = 1;
        walk(1, 8'h20, 16'h8888, 16'hFFFC, -1, 3);
        reset_in = 0;
        expect_fetch("R11 after stall");
    endtask

    task automatic t_so;
        so_in = 1; tick;
        chk("R10 pulse", set_v, 1);
        tick;
        chk("R10 one cycle", set_v, 0);
        tick;
        chk("R10 held level", set_v, 0);
        so_in = 0; tick;
        chk("R10 fall", set_v, 0);
    endtask

    task automatic finish_run;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (3) tick;
        rst_n = 1;
        tick;
        t_reset_state;
        t_power_on;
        t_reset_level;
        t_irq;
        t_irq_mask;
        t_irq_late;
        t_nmi;
        t_priority;
        t_hijack;
        t_late_nmi;
        t_rdy;
        t_so;
        finish_run;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog (all requirements) act=running exp=finished");
        finish_run;
    end
endmodule